// File: doc/BRIEF.md
# Four-Word Broadcast Packet Distributor

This block sits between a simple 32-bit write bus and a row of up to fifteen frame controllers. Software builds a packet by writing four 32-bit words, one per write, into a shared collection buffer. The word-3 write completes the packet. The block then presents the packet on its output for exactly one cycle, to every downstream target that its configuration marks as present.

Two write apertures of 4 KiB each feed the same buffer. In the register aperture, the register selector carried by the packet comes from the address of the completing write. In the data aperture, the selector is always the fixed frame-data code, whatever the address. Neither aperture can be read: reads return zero. Only full 32-bit writes take part. A write with any byte lane disabled is dropped.

Top module: `quad_word_broadcaster`

## Requirements
- R1: A full write whose address bits [3:2] equal 3 completes a packet. `pktValid` is high for exactly the one cycle after the clock edge that samples that write, and it is never high otherwise.
- R2: Full writes with address bits [3:2] equal to 0, 1 or 2 fill buffer words 0, 1 and 2, in any order. In the emitted packet, word k occupies `pktData[32k+31:32k]`, and word 3 is the data of the completing write.
- R3: When the completing write is in the register aperture (`wrAperture`=0), `pktSel` equals bits [9:4] of that write's address.
- R4: When the completing write is in the data aperture (`wrAperture`=1), `pktSel` equals the frame-data code 6'h02, whatever the address.
- R5: `pktTargetEn` equals `targetPresent` as sampled with the completing write, with bit i for target i, during the `pktValid` cycle. It is all-zero in every other cycle.
- R6: A write with `wrStrb` other than 4'b1111 is ignored. It neither changes a buffer word nor completes a packet.
- R7: `rdData` is zero for any read in either aperture.
- R8: Reset clears the buffer words to zero and holds `pktValid` and `pktTargetEn` low. A packet completed right after reset carries zero in words 0 to 2 unless they have been rewritten.
- R9: Buffer words keep their values after a packet is emitted, and both apertures share one buffer. A later packet reuses any word that was not rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAperture | input | 1 | 0 = register aperture, 1 = data aperture |
| wrAddr | input | 12 | Byte offset within the 4 KiB aperture |
| wrData | input | 32 | Write data |
| wrStrb | input | 4 | Byte lane enables; only 4'b1111 is accepted |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 12 | Read byte offset (no effect) |
| rdData | output | 32 | Read data, always zero |
| targetPresent | input | 15 | Configuration: bit i set when target i exists |
| pktValid | output | 1 | One-cycle packet strobe |
| pktSel | output | 6 | Register selector of the packet |
| pktData | output | 128 | Four packet words, word 0 in the low bits |
| pktTargetEn | output | 15 | Per-target delivery enable |

## Verification
The bench fills the buffer out of order and rewrites only word 3 to prove that stale words persist. A design that cleared the buffer on emission, or that swapped lanes, would deliver the wrong words. It sends data-aperture writes whose address bits [9:4] are all ones, so a design that ignored the aperture would report selector 6'h3F instead of 6'h02. It also sends partial-strobe writes to word 1 and to word 3, and issues completing writes on consecutive cycles. A design that accepted partial writes would emit an extra packet or corrupt word 1, and one that stretched or merged strobes would lose a packet. A reset in the middle of collection must make the next packet carry zeros in words 0 to 2.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int SEL_W     = 6;
  localparam int ADDR_W    = 12;
  localparam int SLOT_LSB  = 2;
  localparam int SLOT_W    = $clog2(NUM_WORDS);
  localparam int SEL_LSB   = SLOT_LSB + SLOT_W;
  localparam int PKT_W     = NUM_WORDS * WORD_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_WORDS-2:0] load;     // one-hot buffer word load
    logic                 fire;     // completing write seen
    logic                 fixedSel; // data aperture: use fixed code
    logic [SEL_W-1:0]     addrSel;  // selector from address
  } strobe_t;
endpackage

// File: rtl/qwb_ctrl.sv
module qwb_ctrl
  import qwb_pkg::*;
(
  input  logic              wrEn,
  input  logic              wrAperture,
  input  logic [SLOT_W-1:0] slotBits,
  input  logic [SEL_W-1:0]  selBits,
  input  logic [3:0]        wrStrb,
  output strobe_t           st
);
  logic fullWrite;

  // only complete 32-bit writes participate
  assign fullWrite = wrEn && (wrStrb == 4'b1111);

  for (genvar k = 0; k < NUM_WORDS - 1; k++) begin : g_load
    assign st.load[k] = fullWrite && (slotBits == SLOT_W'(k));
  end

  assign st.fire     = fullWrite && (slotBits == SLOT_W'(NUM_WORDS - 1));
  assign st.fixedSel = wrAperture;
  assign st.addrSel  = selBits;
endmodule

// File: rtl/qwb_datapath.sv
module qwb_datapath
  import qwb_pkg::*;
#(
  parameter int              NUM_TGT  = 15,
  parameter logic [SEL_W-1:0] DATA_SEL = 6'h02
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [NUM_TGT-1:0] targetPresent,
  output logic               pktValid,
  output logic [SEL_W-1:0]   pktSel,
  output logic [PKT_W-1:0]   pktData,
  output logic [NUM_TGT-1:0] pktTargetEn
);
  logic [WORD_W-1:0] heldWord [NUM_WORDS-1];
  logic [PKT_W-1:0]  nextPkt;

  for (genvar k = 0; k < NUM_WORDS - 1; k++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN)
        heldWord[k] <= '0;
      else if (st.load[k])
        heldWord[k] <= wrData;
    end
    assign nextPkt[k*WORD_W +: WORD_W] = heldWord[k];
  end
  // last word comes straight from the completing write
  assign nextPkt[(NUM_WORDS-1)*WORD_W +: WORD_W] = wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid    <= 1'b0;
      pktSel      <= '0;
      pktData     <= '0;
      pktTargetEn <= '0;
    end else begin
      pktValid    <= st.fire;
      pktTargetEn <= st.fire ? targetPresent : '0;
      if (st.fire) begin
        pktData <= nextPkt;
        pktSel  <= st.fixedSel ? DATA_SEL : st.addrSel;
      end
    end
  end
endmodule

// File: rtl/quad_word_broadcaster.sv
module quad_word_broadcaster
  import qwb_pkg::*;
#(
  parameter int              NUM_TGT  = 15,
  parameter logic [SEL_W-1:0] DATA_SEL = 6'h02
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrAperture,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [3:0]          wrStrb,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [WORD_W-1:0]   rdData,
  input  logic [NUM_TGT-1:0]  targetPresent,
  output logic                pktValid,
  output logic [SEL_W-1:0]    pktSel,
  output logic [PKT_W-1:0]    pktData,
  output logic [NUM_TGT-1:0]  pktTargetEn
);
  strobe_t st;
  logic    unusedBits;

  // apertures are write-only; reads see zero
  assign rdData     = '0;
  assign unusedBits = ^{rdEn, rdAddr, wrAddr[ADDR_W-1:SEL_LSB+SEL_W], wrAddr[SLOT_LSB-1:0]};

  qwb_ctrl u_ctrl (
    .wrEn       (wrEn),
    .wrAperture (wrAperture),
    .slotBits   (wrAddr[SLOT_LSB +: SLOT_W]),
    .selBits    (wrAddr[SEL_LSB +: SEL_W]),
    .wrStrb     (wrStrb),
    .st         (st)
  );

  qwb_datapath #(.NUM_TGT(NUM_TGT), .DATA_SEL(DATA_SEL)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .st            (st),
    .wrData        (wrData),
    .targetPresent (targetPresent),
    .pktValid      (pktValid),
    .pktSel        (pktSel),
    .pktData       (pktData),
    .pktTargetEn   (pktTargetEn)
  );
endmodule

// File: rtl/qwb_checker.sv
module qwb_checker
  import qwb_pkg::*;
#(
  parameter int              NUM_TGT  = 15,
  parameter logic [SEL_W-1:0] DATA_SEL = 6'h02
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               wrAperture,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [WORD_W-1:0]  wrData,
  input logic [3:0]         wrStrb,
  input logic [NUM_TGT-1:0] targetPresent,
  input logic               pktValid,
  input logic [SEL_W-1:0]   pktSel,
  input logic [PKT_W-1:0]   pktData,
  input logic [NUM_TGT-1:0] pktTargetEn
);
  assert_fire_cause_R1: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> $past(wrEn && wrStrb == 4'b1111 && wrAddr[SLOT_LSB +: SLOT_W] == SLOT_W'(NUM_WORDS - 1)));

  assert_fire_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrStrb == 4'b1111 && wrAddr[SLOT_LSB +: SLOT_W] == SLOT_W'(NUM_WORDS - 1)) |=> pktValid);

  assert_last_word_R2: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> pktData[(NUM_WORDS-1)*WORD_W +: WORD_W] == $past(wrData));

  assert_reg_sel_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !$past(wrAperture)) |-> pktSel == $past(wrAddr[SEL_LSB +: SEL_W]));

  assert_data_sel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && $past(wrAperture)) |-> pktSel == DATA_SEL);

  assert_tgt_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> pktTargetEn == $past(targetPresent));

  assert_tgt_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |-> pktTargetEn == '0);

  assert_partial_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrStrb != 4'b1111) |=> !pktValid);
endmodule

bind quad_word_broadcaster qwb_checker #(.NUM_TGT(NUM_TGT), .DATA_SEL(DATA_SEL)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAperture(wrAperture), .wrAddr(wrAddr),
  .wrData(wrData), .wrStrb(wrStrb), .targetPresent(targetPresent),
  .pktValid(pktValid), .pktSel(pktSel), .pktData(pktData), .pktTargetEn(pktTargetEn)
);

// File: tb/quad_word_broadcaster_test.sv
module quad_word_broadcaster_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0, wrAperture = 1'b0;
  logic [11:0]  wrAddr = '0, rdAddr = '0;
  logic [31:0]  wrData = '0;
  logic [3:0]   wrStrb = '0;
  logic         rdEn = 1'b0;
  logic [31:0]  rdData;
  logic [14:0]  targetPresent = '0;
  logic         pktValid;
  logic [5:0]   pktSel;
  logic [127:0] pktData;
  logic [14:0]  pktTargetEn;

  typedef struct {
    logic [5:0]   sel;
    logic [127:0] data;
    logic [14:0]  tgt;
    string        tag;
  } exp_t;
  exp_t        expQ[$];
  logic [31:0] mdl [3];
  int          nChecks = 0, nFails = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  quad_word_broadcaster uut (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; wrStrb = '0; rdEn = 1'b0;
  endtask

  task automatic wr(input bit ap, input logic [11:0] addr, input logic [31:0] d,
                    input logic [3:0] strb, input string tag);
    exp_t e;
    @(negedge clk);
    wrEn = 1'b1; wrAperture = ap; wrAddr = addr; wrData = d; wrStrb = strb; rdEn = 1'b0;
    if (strb == 4'b1111) begin
      if (addr[3:2] == 2'd3) begin
        e.sel  = ap ? 6'h02 : addr[9:4];
        e.data = {d, mdl[2], mdl[1], mdl[0]};
        e.tgt  = targetPresent;
        e.tag  = tag;
        expQ.push_back(e);
      end else begin
        mdl[addr[3:2]] = d;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0;
    for (int i = 0; i < 3; i++) mdl[i] = '0;
    repeat (2) @(negedge clk);
    check(pktValid == 1'b0 && pktTargetEn == '0, "R8 reset outputs", {112'd0, pktTargetEn, pktValid}, '0);
    rstN = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (pktValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1/R6 unexpected packet", pktData, '0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(pktSel == e.sel, {e.tag, " sel"}, {122'd0, pktSel}, {122'd0, e.sel});
          check(pktData == e.data, {e.tag, " data"}, pktData, e.data);
          check(pktTargetEn == e.tgt, {e.tag, " tgtEn"}, {113'd0, pktTargetEn}, {113'd0, e.tgt});
        end
      end else if (pktTargetEn != '0) begin
        check(1'b0, "R5 enable without packet", {113'd0, pktTargetEn}, '0);
      end
    end
  end

  task automatic finishReport();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      finishReport();
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) mdl[i] = '0;
    doReset();
    check(rdData == '0, "R7 read after reset", {96'd0, rdData}, '0);

    // R8: only word 3 after reset -> zero words 0..2
    targetPresent = 15'h0005;
    wr(0, 12'h05C, 32'hAAAA_0003, 4'hF, "R8 post-reset packet");
    idle();

    // R2 R3 R5: full packet in register aperture, all targets
    targetPresent = 15'h7FFF;
    wr(0, 12'h2A0, 32'h1111_0000, 4'hF, "R2");
    wr(0, 12'h2A4, 32'h1111_0001, 4'hF, "R2");
    wr(0, 12'h2A8, 32'h1111_0002, 4'hF, "R2");
    wr(0, 12'h2AC, 32'h1111_0003, 4'hF, "R3 reg aperture sel");
    idle();

    // R4: data aperture with all-ones selector bits in address
    targetPresent = 15'h0001;
    wr(1, 12'hFF0, 32'h2222_0000, 4'hF, "R4");
    wr(1, 12'hFF4, 32'h2222_0001, 4'hF, "R4");
    wr(1, 12'hFF8, 32'h2222_0002, 4'hF, "R4");
    wr(1, 12'hFFC, 32'h2222_0003, 4'hF, "R4 data aperture fixed sel");
    idle();

    // R2: out-of-order fill
    targetPresent = 15'h4210;
    wr(0, 12'h018, 32'h3333_0002, 4'hF, "R2");
    wr(0, 12'h010, 32'h3333_0000, 4'hF, "R2");
    wr(0, 12'h014, 32'h3333_0001, 4'hF, "R2");
    wr(0, 12'h01C, 32'h3333_0003, 4'hF, "R2 out-of-order fill");
    idle();

    // R9 R5: rewrite only word 3 via data aperture, no targets present
    targetPresent = 15'h0000;
    wr(1, 12'h00C, 32'h4444_0003, 4'hF, "R9 stale words reused / R5 none present");
    idle();

    // R6: partial-strobe writes ignored
    targetPresent = 15'h2AAA;
    wr(0, 12'h004, 32'hDEAD_BEEF, 4'b0011, "R6");
    wr(0, 12'h00C, 32'hDEAD_BEEF, 4'b0111, "R6");
    idle(); idle();
    check(pktValid == 1'b0, "R6 partial word3 no packet", {127'd0, pktValid}, '0);
    wr(0, 12'h3CC, 32'h5555_0003, 4'hF, "R6 word1 untouched by partial write");
    idle();

    // R7: reads in both apertures
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 12'h00C;
    #1 check(rdData == '0, "R7 read register aperture", {96'd0, rdData}, '0);
    @(negedge clk);
    rdAddr = 12'hFFC;
    #1 check(rdData == '0, "R7 read data aperture", {96'd0, rdData}, '0);
    idle();

    // R1: back-to-back completing writes -> two packets
    targetPresent = 15'h1234;
    wr(0, 12'h10C, 32'h6666_0003, 4'hF, "R1 back-to-back first");
    wr(0, 12'h20C, 32'h7777_0003, 4'hF, "R1 back-to-back second");
    idle(); idle(); idle();

    // R8: reset during collection
    wr(0, 12'h000, 32'h8888_0000, 4'hF, "R8");
    wr(0, 12'h004, 32'h8888_0001, 4'hF, "R8");
    idle();
    doReset();
    targetPresent = 15'h7001;
    wr(0, 12'h08C, 32'h9999_0003, 4'hF, "R8 reset clears buffer");
    idle(); idle(); idle();

    check(expQ.size() == 0, "R1 all expected packets seen", {96'd0, 32'(expQ.size())}, '0);
    done = 1;
    finishReport();
  end
endmodule